// File: doc/BRIEF.md
# Bidirectional Row Scan Driver Core

This block is the logic side of a row scan driver for a display panel. Serial row-select data arrives on one of two serial pins and moves into a 64-stage shift register, one stage for each rising edge of an external shift clock. A direction input picks which pin receives the data and which pin passes it on, so that devices can be chained in either direction. The shift clock and the other asynchronous inputs are sampled by a faster system clock through two-flop synchronizers, and shifting happens on a detected rising edge.

A strobe-controlled holding stage sits behind the register. While strobe is low it follows the register, and while strobe is high it keeps its value. Blank and polarity controls then form the 64 logic-level drive bits. A clear input empties the register at once and leaves the holding stage alone. Each serial pin is split into an input, an output and an output enable, so the pad ring can build the tristate buffer.

Top module: `scan_row_driver`

## Requirements
- R1: After reset the register and holding stage are all zero and the drive bits are zero with polarity low. The direction is forward, so `sb_oe` is 1 and `sa_oe` is 0.
- R2: Forward mode (`dir_fwd` = 1). Each detected shift edge loads the value from `sa_in` into stage 1 (bit 0) and moves stage n to stage n+1. `sb_out` carries stage 64 (bit 63), so the first bit entered appears there after 64 shifts.
- R3: Reverse mode (`dir_fwd` = 0). Each detected shift edge loads the value from `sb_in` into stage 64 (bit 63) and moves stage n to stage n-1. `sa_out` carries stage 1 (bit 0).
- R4: The output enables follow the synchronized direction. In forward mode `sb_oe` = 1 and `sa_oe` = 0. In reverse mode the two values are swapped.
- R5: While `clr` is high, all register stages are 0 at once, with no clock edge needed. The holding stage is not changed by the clear.
- R6: While the synchronized strobe is low, the holding stage copies the register on every system clock. While strobe is high, the holding stage keeps its value.
- R7: With `blank` high, every drive bit equals `polarity`, whatever the holding stage contains.
- R8: With `blank` low, the drive bits equal the holding stage when `polarity` is 0, and its bitwise inverse when `polarity` is 1.
- R9: A rising `sclk` shifts exactly once. The shift shows up on the third system clock edge after the change, using the serial data and direction sampled with the same delay. A level held high or a falling edge causes no shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Shift clock, asynchronous |
| dir_fwd | input | 1 | 1 = forward (in on A, out on B), 0 = reverse |
| clr | input | 1 | Active-high clear of the shift register |
| strobe | input | 1 | 0 = holding stage follows, 1 = holds |
| blank | input | 1 | Forces all drive bits to the polarity level |
| polarity | input | 1 | Inverts the drive bits |
| sa_in | input | 1 | Serial pin A input value |
| sb_in | input | 1 | Serial pin B input value |
| sa_out | output | 1 | Serial pin A output value (stage 1) |
| sa_oe | output | 1 | Serial pin A output enable |
| sb_out | output | 1 | Serial pin B output value (stage 64) |
| sb_oe | output | 1 | Serial pin B output enable |
| drive | output | 64 | Row drive bits, bit 0 = stage 1 |

## Verification
A wrong register stage stays hidden until it either reaches the cascade pin, which can take up to 64 shift edges, or is copied into the holding stage while strobe is low. From there it shows on the drive bits one system clock later. A holding-stage error is visible at once on the drive bits unless blank is high, so blank masks these faults. Polarity only inverts them, so they stay visible. Direction and edge-detection errors show as one-stage offsets in the drive pattern and as the wrong pin being enabled two cycles after `dir_fwd` changes.

// File: rtl/scan_row_driver.sv
module scan_row_driver #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         dir_fwd,
  input  logic         clr,
  input  logic         strobe,
  input  logic         blank,
  input  logic         polarity,
  input  logic         sa_in,
  input  logic         sb_in,
  output logic         sa_out,
  output logic         sa_oe,
  output logic         sb_out,
  output logic         sb_oe,
  output logic [W-1:0] drive
);

  logic [2:0]   sclk_q;
  logic [1:0]   dir_q, stb_q, a_q, b_q;
  logic [W-1:0] sreg, lat;
  logic         rise, fwd, din;

  assign rise = sclk_q[1] & ~sclk_q[2];
  assign fwd  = dir_q[1];
  assign din  = fwd ? a_q[1] : b_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      dir_q  <= '1;
      stb_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      lat    <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      dir_q  <= {dir_q[0], dir_fwd};
      stb_q  <= {stb_q[0], strobe};
      a_q    <= {a_q[0], sa_in};
      b_q    <= {b_q[0], sb_in};
      if (!stb_q[1]) lat <= sreg;
    end
  end

  always_ff @(posedge clk or negedge rst_n or posedge clr) begin
    if (!rst_n)      sreg <= '0;
    else if (clr)    sreg <= '0;
    else if (rise)   sreg <= fwd ? {sreg[W-2:0], din} : {din, sreg[W-1:1]};
  end

  assign sa_out = sreg[0];
  assign sb_out = sreg[W-1];
  assign sa_oe  = ~fwd;
  assign sb_oe  = fwd;
  assign drive  = blank ? {W{polarity}} : (lat ^ {W{polarity}});

endmodule

// File: rtl/scan_row_driver_chk.sv
module scan_row_driver_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         strobe,
  input logic         blank,
  input logic         polarity,
  input logic         dir_fwd,
  input logic         sa_oe,
  input logic         sb_oe,
  input logic [W-1:0] drive,
  input logic [W-1:0] sreg,
  input logic [W-1:0] lat
);

  logic [1:0] up;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        up <= '0;
    else if (up != 2'd3) up <= up + 2'd1;
  end

  assert_oe_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up == 2'd3) |-> (sb_oe == $past(dir_fwd, 2) && sa_oe == !$past(dir_fwd, 2)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (sreg == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up == 2'd3 && strobe && $past(strobe) && $past(strobe, 2)) |=> $stable(lat));

  assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (drive == {W{polarity}}));

  assert_fwd_shift_R2: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (up == 2'd3 && !$past(clr) && $past(sb_oe) && !$stable(sreg))
      |-> (sreg[W-1:1] == $past(sreg[W-2:0])));

  assert_rev_shift_R3: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (up == 2'd3 && !$past(clr) && !$past(sb_oe) && !$stable(sreg))
      |-> (sreg[W-2:0] == $past(sreg[W-1:1])));

endmodule

bind scan_row_driver scan_row_driver_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(strobe), .blank(blank),
  .polarity(polarity), .dir_fwd(dir_fwd), .sa_oe(sa_oe), .sb_oe(sb_oe),
  .drive(drive), .sreg(sreg), .lat(lat)
);

// File: tb/test_scan_row_driver.sv
module test_scan_row_driver;
  localparam int W = 64;

  logic clk = 0, rst_n = 0, sclk = 0, dir_fwd = 1, clr = 0;
  logic strobe = 0, blank = 0, polarity = 0, sa_in = 0, sb_in = 0;
  logic sa_out, sa_oe, sb_out, sb_oe;
  logic [W-1:0] drive;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scan_row_driver #(.W(W)) i_scan_row_driver (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .dir_fwd(dir_fwd), .clr(clr),
    .strobe(strobe), .blank(blank), .polarity(polarity),
    .sa_in(sa_in), .sb_in(sb_in), .sa_out(sa_out), .sa_oe(sa_oe),
    .sb_out(sb_out), .sb_oe(sb_oe), .drive(drive)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: history of raw input samples, one per clock
  logic [W-1:0] m_sreg, m_lat;
  logic [3:0] h_sclk, h_a, h_b, h_dir, h_stb;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sreg = '0; m_lat = '0;
      h_sclk = '0; h_a = '0; h_b = '0; h_dir = '1; h_stb = '0;
    end else begin
      logic [W-1:0] pre;
      logic d;
      pre = clr ? '0 : m_sreg;
      if (!h_stb[1]) m_lat = pre;
      d = h_dir[1] ? h_a[1] : h_b[1];
      if (clr) m_sreg = '0;
      else if (h_sclk[1] && !h_sclk[2])
        m_sreg = h_dir[1] ? {m_sreg[W-2:0], d} : {d, m_sreg[W-1:1]};
      h_sclk = {h_sclk[2:0], sclk};
      h_a    = {h_a[2:0], sa_in};
      h_b    = {h_b[2:0], sb_in};
      h_dir  = {h_dir[2:0], dir_fwd};
      h_stb  = {h_stb[2:0], strobe};
    end
    #1;
    if (!done) begin
      check("R4 output enables", {sa_oe, sb_oe}, {!h_dir[1], h_dir[1]});
      check(h_dir[1] ? "R2 serial outputs" : "R3 serial outputs",
            {sa_out, sb_out}, {m_sreg[0], m_sreg[W-1]});
      check(blank ? "R7 blank drive" : (polarity ? "R8 inverted drive" : "R6 latched drive"),
            drive, blank ? {W{polarity}} : (m_lat ^ {W{polarity}}));
    end
  end

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(logic b);
    if (dir_fwd) sa_in = b; else sb_in = b;
    sclk = 1;
    wait_neg(3);
    sclk = 0;
    wait_neg(3);
  endtask

  initial begin
    logic [W-1:0] fbits, rbits, exp;
    wait_neg(3);
    rst_n = 1;
    wait_neg(4);
    check("R1 reset drive", drive, '0);
    check("R1 reset enables", {sa_oe, sb_oe}, 2'b01);

    // forward fill while holding
    strobe = 1;
    wait_neg(3);
    for (int i = 0; i < W; i++) fbits[i] = (i == 0) || (i % 3 == 2);
    for (int i = 0; i < W; i++) shift_bit(fbits[i]);
    check("R2 first bit at cascade pin", sb_out, fbits[0]);
    check("R6 hold while strobe high", drive, '0);
    for (int j = 0; j < W; j++) exp[j] = fbits[W-1-j];
    strobe = 0;
    wait_neg(4);
    check("R6 transfer with strobe low", drive, exp);
    strobe = 1;
    wait_neg(4);

    polarity = 1; wait_neg(1);
    check("R8 inverted", drive, ~exp);
    blank = 1; wait_neg(1);
    check("R7 blank with polarity high", drive, '1);
    polarity = 0; wait_neg(1);
    check("R7 blank with polarity low", drive, '0);
    blank = 0; wait_neg(1);

    clr = 1; wait_neg(3);
    check("R5 latch kept on clear", drive, exp);
    check("R5 register cleared", {sa_out, sb_out}, 2'b00);
    clr = 0; wait_neg(2);

    // reverse, transparent
    dir_fwd = 0; wait_neg(4);
    check("R4 reverse enables", {sa_oe, sb_oe}, 2'b10);
    strobe = 0;
    for (int i = 0; i < W; i++) rbits[i] = (i == 0) || (i % 5 == 1);
    for (int i = 0; i < W; i++) shift_bit(rbits[i]);
    check("R3 first bit at pin A", sa_out, rbits[0]);
    wait_neg(2);
    check("R3 reverse pattern", drive, rbits);

    // long high level shifts once
    sb_in = 1; sclk = 1; wait_neg(20);
    sclk = 0; wait_neg(20);
    check("R9 single shift per edge", drive[W-1:W-2], {1'b1, rbits[W-1]});
    check("R9 tail after single shift", drive[W-3:0], rbits[W-2:1]);

    dir_fwd = 1; wait_neg(6);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule